// File: doc/BRIEF.md
# Serial DAC Frame Generator

This block is the host-side master for a serial digital-to-analog converter that takes 16-bit words framed by chip select and frame sync. A client hands over a 12-bit output code, a speed-select bit and a power-down bit through a valid/ready handshake. The block packs them into one 16-bit word and shifts it out, most significant bit first. Each line transition is placed by its own timing counter, so every setup, hold and pulse-width minimum of the converter's serial port is met.

A frame follows a fixed order. Chip select falls. Frame sync falls. Sixteen serial clock pulses follow, and the converter samples on each falling edge. Frame sync then rises, and chip select rises last. Every interval is a parameter counted in system-clock cycles. Frame sync must also stay high for a minimum time between frames. When the natural spacing of the sequence cannot guarantee that time, a small counter holds off the next frame. A one-cycle done pulse marks the end of each word.

Top module: `dac_frame_host`

## Requirements
- R1: The transmitted word has bit 14 = speed bit, bit 13 = power-down bit, bits 11..0 = code, and bits 15 and 12 = 0.
- R2: Chip select is low for at least T_CS_FS cycles before frame sync falls, and frame sync falls only while chip select is low.
- R3: Frame sync is low for at least T_FS_CK cycles before the first falling serial clock edge of a frame.
- R4: Every serial clock high phase lasts at least T_CLK_HI cycles and every low phase between pulses at least T_CLK_LO cycles; a frame has exactly 16 falling edges.
- R5: The data line changes only in the cycle where the serial clock rises, so it is stable across each falling edge; bits leave most significant first.
- R6: Frame sync rises at least T_END_FS cycles after the 16th falling edge, and chip select rises at least T_END_CS cycles after frame sync rises, with frame sync already high.
- R7: Frame sync stays high for at least T_FS_HI cycles between two frames, including back-to-back frames.
- R8: The ready output is high only when no frame is in progress and is low from acceptance until chip select is high again; a request that arrives while busy is held and sent afterwards, never dropped.
- R9: done is a single-cycle pulse in exactly the cycle in which chip select returns high.
- R10: During and right after reset: chip select high, frame sync high, serial clock low, data low, done low, ready high.
- R11: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a word |
| req_ready | output | 1 | Block can accept a word this cycle |
| req_code | input | 12 | Output code to send |
| req_fast | input | 1 | Speed-select bit for the word |
| req_pwrdn | input | 1 | Power-down bit for the word |
| cs_n | output | 1 | Chip select, active low |
| fs | output | 1 | Frame sync, falls to start a frame |
| sclk | output | 1 | Serial clock, data sampled on falling edge |
| sdo | output | 1 | Serial data out |
| done | output | 1 | One-cycle pulse when a word has been sent |

## Verification
The hardest case to reach is the one where the frame-sync high-time counter actually stretches the chip-select lead. That needs a request already waiting when the previous frame ends, with a required high time longer than the natural tail-to-head spacing. The bench sets that minimum above the spacing the sequence gives by itself. It then offers requests with zero idle gap, so they are presented while the block is busy and accepted the cycle it returns to idle. Between frames it measures every frame-sync high interval and every chip-select lead. Random codes and control bits, mixed with all-zero, all-one and alternating patterns, exercise the word layout and bit order.

// File: rtl/dac_frame_pkg.sv
`timescale 1ns/1ps
package dac_frame_pkg;

   localparam int WORD_W    = 16;
   localparam int CODE_W    = 12;
   localparam int SPEED_POS = 14;
   localparam int PWRDN_POS = 13;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CS_LEAD,
      ST_FS_LEAD,
      ST_CLK_HI,
      ST_CLK_LO,
      ST_FS_TAIL,
      ST_CS_TAIL
   } phase_t;

   function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] code,
                                                   input logic fast,
                                                   input logic pwrdn);
      logic [WORD_W-1:0] w;
      w                = '0;
      w[CODE_W-1:0]    = code;
      w[SPEED_POS]     = fast;
      w[PWRDN_POS]     = pwrdn;
      return w;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_step_timer.sv
`timescale 1ns/1ps
module dac_step_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/dac_word_shifter.sv
`timescale 1ns/1ps
module dac_word_shifter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] word,
   input  logic             shift,
   output logic             head
);

   logic [WIDTH-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sreg <= '0;
      else if (load)   sreg <= word;
      else if (shift)  sreg <= {sreg[WIDTH-2:0], 1'b0};
   end

   assign head = sreg[WIDTH-1];

endmodule

// File: rtl/dac_frame_host.sv
`timescale 1ns/1ps
module dac_frame_host
   import dac_frame_pkg::*;
#(
   parameter int T_CS_FS  = 3,
   parameter int T_FS_CK  = 2,
   parameter int T_CLK_HI = 7,
   parameter int T_CLK_LO = 7,
   parameter int T_END_FS = 3,
   parameter int T_END_CS = 3,
   parameter int T_FS_HI  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic              req_fast,
   input  logic              req_pwrdn,
   output logic              cs_n,
   output logic              fs,
   output logic              sclk,
   output logic              sdo,
   output logic              done
);

   localparam int T_MAX   = max_of(max_of(max_of(T_CS_FS, T_FS_CK), max_of(T_CLK_HI, T_CLK_LO)),
                                   max_of(T_END_FS, T_END_CS));
   localparam int CNT_W   = $clog2(T_MAX + 1);
   localparam int BIT_W   = $clog2(WORD_W);
   localparam int SEQ_GAP = T_END_CS + 1 + T_CS_FS;

   localparam logic [CNT_W-1:0] LD_CS_FS  = CNT_W'(T_CS_FS - 1);
   localparam logic [CNT_W-1:0] LD_FS_CK  = CNT_W'(T_FS_CK - 1);
   localparam logic [CNT_W-1:0] LD_HI     = CNT_W'(T_CLK_HI - 1);
   localparam logic [CNT_W-1:0] LD_LO     = CNT_W'(T_CLK_LO - 1);
   localparam logic [CNT_W-1:0] LD_END_FS = CNT_W'(T_END_FS - 1);
   localparam logic [CNT_W-1:0] LD_END_CS = CNT_W'(T_END_CS - 1);

   initial begin
      assert (T_CS_FS  >= 1) else $error("T_CS_FS must be at least 1");
      assert (T_FS_CK  >= 1) else $error("T_FS_CK must be at least 1");
      assert (T_CLK_HI >= 1) else $error("T_CLK_HI must be at least 1");
      assert (T_CLK_LO >= 1) else $error("T_CLK_LO must be at least 1");
      assert (T_END_FS >= 1) else $error("T_END_FS must be at least 1");
      assert (T_END_CS >= 1) else $error("T_END_CS must be at least 1");
      assert (T_FS_HI  >= 1) else $error("T_FS_HI must be at least 1");
   end

   phase_t           state;
   logic             adv;
   logic             last_bit;
   logic             tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load;
   logic             sh_shift;
   logic             sh_head;
   logic [BIT_W-1:0] bit_idx;
   logic             gap_ok;
   logic             cs_n_q, fs_q, sclk_q, sdo_q, done_q;

   // Phase timer: each phase holds for its programmed cycle count
   dac_step_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (adv),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   // Word register, MSB presented at head
   dac_word_shifter #(.WIDTH(WORD_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .word  (pack_word(req_code, req_fast, req_pwrdn)),
      .shift (sh_shift),
      .head  (sh_head)
   );

   // Frame-sync high-time guard, only built when the sequence alone cannot ensure it
   generate
      if (T_FS_HI > SEQ_GAP) begin : g_gap_cnt
         localparam int GW = $clog2(T_FS_HI + 1);
         logic [GW-1:0] hi_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hi_cnt <= '0;
            else if (!fs_q)                 hi_cnt <= '0;
            else if (hi_cnt != GW'(T_FS_HI)) hi_cnt <= hi_cnt + 1'b1;
         end
         assign gap_ok = (hi_cnt >= GW'(T_FS_HI - 1));
      end else begin : g_gap_free
         assign gap_ok = 1'b1;
      end
   endgenerate

   assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

   always_comb begin
      case (state)
         ST_IDLE:    adv = req_valid;
         ST_CS_LEAD: adv = tmr_done && gap_ok;
         default:    adv = tmr_done;
      endcase
   end

   always_comb begin
      case (state)
         ST_IDLE:    tmr_val = LD_CS_FS;
         ST_CS_LEAD: tmr_val = LD_FS_CK;
         ST_FS_LEAD: tmr_val = LD_HI;
         ST_CLK_HI:  tmr_val = LD_LO;
         ST_CLK_LO:  tmr_val = last_bit ? LD_END_FS : LD_HI;
         ST_FS_TAIL: tmr_val = LD_END_CS;
         default:    tmr_val = '0;
      endcase
   end

   assign sh_load  = (state == ST_IDLE) && req_valid;
   assign sh_shift = adv && ((state == ST_FS_LEAD) || ((state == ST_CLK_LO) && !last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cs_n_q  <= 1'b1;
         fs_q    <= 1'b1;
         sclk_q  <= 1'b0;
         sdo_q   <= 1'b0;
         done_q  <= 1'b0;
         bit_idx <= '0;
      end else begin
         done_q <= 1'b0;
         if (adv) begin
            case (state)
               ST_IDLE: begin
                  cs_n_q <= 1'b0;
                  state  <= ST_CS_LEAD;
               end
               ST_CS_LEAD: begin
                  fs_q  <= 1'b0;
                  state <= ST_FS_LEAD;
               end
               ST_FS_LEAD: begin
                  sclk_q  <= 1'b1;
                  sdo_q   <= sh_head;
                  bit_idx <= '0;
                  state   <= ST_CLK_HI;
               end
               ST_CLK_HI: begin
                  sclk_q <= 1'b0;
                  state  <= ST_CLK_LO;
               end
               ST_CLK_LO: begin
                  if (last_bit) begin
                     state <= ST_FS_TAIL;
                  end else begin
                     sclk_q  <= 1'b1;
                     sdo_q   <= sh_head;
                     bit_idx <= bit_idx + 1'b1;
                     state   <= ST_CLK_HI;
                  end
               end
               ST_FS_TAIL: begin
                  fs_q  <= 1'b1;
                  state <= ST_CS_TAIL;
               end
               default: begin
                  cs_n_q <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            endcase
         end
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign cs_n      = cs_n_q;
   assign fs        = fs_q;
   assign sclk      = sclk_q;
   assign sdo       = sdo_q;
   assign done      = done_q;

   AST_SCLK_PARKED:    assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);                            // R11
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> !req_ready);                      // R8
   AST_DONE_AT_CS_UP:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !$past(cs_n)));          // R9
   AST_SDO_ON_RISE:    assert property (@(posedge clk) disable iff (!rst_n) (sdo != $past(sdo)) |-> (sclk && !$past(sclk))); // R5
   AST_FS_UNDER_CS:    assert property (@(posedge clk) disable iff (!rst_n) $fell(fs) |-> !cs_n);                       // R2
   AST_CS_AFTER_FS:    assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> fs);                        // R6

endmodule

// File: tb/dac_frame_host_tb_top.sv
`timescale 1ns/1ps
module dac_frame_host_tb_top;

   localparam int P_CS_FS  = 3;
   localparam int P_FS_CK  = 2;
   localparam int P_CLK_HI = 7;
   localparam int P_CLK_LO = 7;
   localparam int P_END_FS = 3;
   localparam int P_END_CS = 3;
   localparam int P_FS_HI  = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_code = '0;
   logic        req_fast = 1'b0;
   logic        req_pwrdn = 1'b0;
   logic        cs_n, fs, sclk, sdo, done;

   always #2 clk = ~clk;

   dac_frame_host #(
      .T_CS_FS (P_CS_FS), .T_FS_CK (P_FS_CK), .T_CLK_HI(P_CLK_HI), .T_CLK_LO(P_CLK_LO),
      .T_END_FS(P_END_FS), .T_END_CS(P_END_CS), .T_FS_HI (P_FS_HI)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_code(req_code), .req_fast(req_fast), .req_pwrdn(req_pwrdn),
      .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdo(sdo), .done(done)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int sent = 0;
   int frames = 0;
   logic [15:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] model_word(input logic [11:0] code, input logic f, input logic p);
      return {1'b0, f, p, 1'b0, code};
   endfunction

   // Port monitor, sampled between clock edges
   bit          mon_on = 0;
   logic        p_cs, p_fs, p_sclk, p_sdo;
   int          t_cs_fall, t_fs_fall, t_fs_rise, t_rise, t_fall;
   int          nfalls = 0;
   bit          seen_fs_rise = 0;
   logic [15:0] got = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mon_on) begin
            mon_on = 1;
            p_cs = cs_n; p_fs = fs; p_sclk = sclk; p_sdo = sdo;
            t_cs_fall = 0; t_fs_fall = 0; t_fs_rise = 0; t_rise = 0; t_fall = 0;
         end else begin
            t_cs_fall++; t_fs_fall++; t_fs_rise++; t_rise++; t_fall++;
            if (cs_n) chk(!sclk, "R11", "sclk while deselected", sclk, 0);
            if (!cs_n) chk(!req_ready, "R8", "ready while busy", req_ready, 0);
            if (done) chk(cs_n && !p_cs, "R9", "done away from cs rise", cs_n, 1);
            if (sdo !== p_sdo) chk(sclk && !p_sclk, "R5", "sdo changed off rising edge", sclk, 1);
            if (p_cs && !cs_n) t_cs_fall = 0;
            if (p_fs && !fs) begin
               chk(!cs_n, "R2", "fs fell without cs", cs_n, 0);
               chk(t_cs_fall >= P_CS_FS, "R2", "cs lead", t_cs_fall, P_CS_FS);
               if (seen_fs_rise) chk(t_fs_rise >= P_FS_HI, "R7", "fs high gap", t_fs_rise, P_FS_HI);
               t_fs_fall = 0;
            end
            if (p_sclk && !sclk) begin
               if (nfalls == 0) chk(t_fs_fall >= P_FS_CK, "R3", "fs lead to first fall", t_fs_fall, P_FS_CK);
               chk(t_rise >= P_CLK_HI, "R4", "sclk high width", t_rise, P_CLK_HI);
               chk(sdo === p_sdo, "R5", "sdo unstable at fall", sdo, p_sdo);
               got = {got[14:0], sdo};
               nfalls++;
               t_fall = 0;
            end
            if (!p_sclk && sclk) begin
               if (nfalls > 0) chk(t_fall >= P_CLK_LO, "R4", "sclk low width", t_fall, P_CLK_LO);
               t_rise = 0;
            end
            if (!p_fs && fs) begin
               chk(nfalls == 16, "R4", "falls before fs rise", nfalls, 16);
               chk(t_fall >= P_END_FS, "R6", "fs tail after last fall", t_fall, P_END_FS);
               t_fs_rise = 0;
               seen_fs_rise = 1;
            end
            if (!p_cs && cs_n) begin
               chk(fs, "R6", "fs low at cs rise", fs, 1);
               chk(t_fs_rise >= P_END_CS, "R6", "cs tail after fs rise", t_fs_rise, P_END_CS);
               chk(done, "R9", "done at cs rise", done, 1);
               if (exp_q.size() == 0) begin
                  chk(0, "R8", "frame without request", got, 0);
               end else begin
                  logic [15:0] e;
                  e = exp_q.pop_front();
                  chk(got === e, "R1", "word content", got, e);
               end
               frames++;
               nfalls = 0;
            end
            p_cs = cs_n; p_fs = fs; p_sclk = sclk; p_sdo = sdo;
         end
      end
   end

   task automatic send(input logic [11:0] code, input logic f, input logic p, input int idle);
      req_code  = code;
      req_fast  = f;
      req_pwrdn = p;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      exp_q.push_back(model_word(code, f, p));
      sent++;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   task automatic reset_check(input string when);
      chk(cs_n === 1'b1, "R10", {when, " cs_n"}, cs_n, 1);
      chk(fs === 1'b1, "R10", {when, " fs"}, fs, 1);
      chk(sclk === 1'b0, "R10", {when, " sclk"}, sclk, 0);
      chk(sdo === 1'b0, "R10", {when, " sdo"}, sdo, 0);
      chk(done === 1'b0, "R10", {when, " done"}, done, 0);
      chk(req_ready === 1'b1, "R10", {when, " ready"}, req_ready, 1);
   endtask

   initial begin
      void'($urandom(32'h5A17C0DE));
      repeat (4) @(negedge clk);
      reset_check("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      reset_check("after reset");

      // Directed: extremes and alternating bits; back-to-back to stress the fs gap (R7)
      send(12'h000, 1'b0, 1'b0, 0);
      send(12'hFFF, 1'b1, 1'b1, 0);
      send(12'hAAA, 1'b1, 1'b0, 0);
      send(12'h555, 1'b0, 1'b1, 30);
      send(12'h800, 1'b0, 1'b0, 5);

      // Random mix of idle gaps and held-off requests (R8)
      for (int i = 0; i < 40; i++) begin
         int gap;
         gap = (($urandom % 3) == 0) ? int'($urandom % 40) : 0;
         send(12'($urandom), 1'($urandom), 1'($urandom), gap);
      end

      while (exp_q.size() != 0 || !cs_n) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(frames == sent, "R8", "frames sent vs accepted", frames, sent);
      chk(exp_q.size() == 0, "R8", "requests left over", exp_q.size(), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", frames, sent);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule